// File: doc/BRIEF.md
# Mesochronous Ring-Buffer Link Synchronizer

This block moves data words between two clock domains that run at the same frequency with an unknown but constant phase offset. The sending domain owns a ring of data registers, each with a valid flag. The receiving domain owns a ring of credit tokens of the same depth. Each domain has one ring pointer. The pointer advances on every clock of its own domain and never stops. The read pointer starts `SPREAD` entries ahead of the write pointer, so an entry is never written and read in the same clock window. Because of this no pointer or flag has to be resynchronized.

The receiver controls flow through the tokens. On every read cycle it writes a token for the entry at its pointer: 1 lets the sender reuse that entry, 0 blocks it. When the token at the write pointer is 0, the sender sees `full_o`, and its push is discarded. Every word shown with `empty_o` low is taken in that same cycle. Words that are in flight while a stall is held must be absorbed by a holding store downstream. To tolerate a drift of up to k periods, use `DEPTH = 4 + 2k` and `SPREAD = DEPTH/2`.

Top module: `meso_sync`

## Requirements
- R1: After reset the write pointer is 0 and the read pointer is `SPREAD` (default 2). Every token is 1, so `full_o` is 0. Every valid flag is 0, so `empty_o` is 1.
- R2: Each pointer advances by one, modulo `DEPTH`, on every clock of its own domain, including while the link is stalled or full.
- R3: A push while the token at the write pointer is 1 stores `wdata_i` in that entry and sets its valid flag. Each pushed word reaches `rdata_o` exactly once and in push order.
- R4: Back-to-back pushes with no stall appear on consecutive read cycles, giving one word per clock.
- R5: When the token at the write pointer is 0, `full_o` is 1 for that cycle. The entry's data is left unchanged, its valid flag is cleared, and any push in that cycle is discarded.
- R6: On every read clock, the token of the entry at the read pointer is set to the inverse of `stall_i` (1 = send allowed, 0 = hold).
- R7: `empty_o` is the inverse of the valid flag at the read pointer, and `rdata_o` is that entry's data.
- R8: In a write cycle with no push and a token of 1, the entry's valid flag is cleared, so a word is never shown twice.
- R9: `rst_ni` asserts both domains asynchronously. Each domain releases reset through its own two-flop synchronizer. Transfer is correct for any fixed phase offset, including offsets near zero and near one full period.
- R10: If `stall_i` is held, `full_o` rises within `DEPTH` cycles and the output goes empty. After release, `full_o` falls and all pending words are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Sending-domain clock |
| rclk_i | input | 1 | Receiving-domain clock, same frequency as wclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset, synchronized per domain |
| push_i | input | 1 | Sender offers `wdata_i` this cycle |
| wdata_i | input | DATA_W | Word to send |
| full_o | output | 1 | Token at write pointer forbids writing; push discarded |
| stall_i | input | 1 | Receiver requests a hold (writes 0 tokens) |
| rdata_o | output | DATA_W | Data of entry at read pointer |
| empty_o | output | 1 | No valid word at read pointer |

## Verification
The assertions assume that both clocks have the same period and a phase offset that stays fixed between resets. They also assume that every word presented with `empty_o` low is taken by the receiver in that cycle. The bench produces both clocks from one source with a fixed delay, and it changes that delay only while reset is held. Offsets from half a nanosecond up to just under a full period are covered. Its receiver records every non-empty read cycle, which models an unbounded downstream store. Its sender checks `full_o` away from the clock edge before it pushes, except for one deliberate push into a full link.

// File: rtl/meso_sync_pkg.sv
package meso_sync_pkg;
  // next index on a ring of given depth
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/meso_rst_sync.sv
module meso_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/meso_wr_side.sv
module meso_wr_side #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [DEPTH-1:0]               tok_i,
  output logic [DEPTH-1:0][DATA_W-1:0]   data_o,
  output logic [DEPTH-1:0]               vld_o,
  output logic                           full_o
);
  import meso_sync_pkg::*;

  logic [PTR_W-1:0]             wp_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             vld_q;
  logic                         tok_sel;
  logic                         wr_ok;

  assign tok_sel = tok_i[wp_q];
  assign wr_ok   = push_i & tok_sel;
  assign full_o  = ~tok_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= '0;
    else         wp_q <= PTR_W'(ring_next(int'(wp_q), DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              sel;
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    assign sel = (wp_q == PTR_W'(i));

    // valid follows the write outcome of the selected entry; blocked or idle clears it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (sel) v_q <= wr_ok;
    end

    always_ff @(posedge clk_i) begin
      if (sel && wr_ok) d_q <= wdata_i;
    end

    assign vld_q[i]  = v_q;
    assign data_q[i] = d_q;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  assert_wp_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> wp_q == '0);

  assert_wp_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> wp_q == PTR_W'(ring_next(int'($past(wp_q)), DEPTH)));

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> vld_q[$past(wp_q)] && data_q[$past(wp_q)] == $past(wdata_i));

  assert_blocked_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_sel |=> $stable(data_q) && !vld_q[$past(wp_q)]);

  assert_idle_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> !vld_q[$past(wp_q)]);
endmodule

// File: rtl/meso_rd_side.sv
module meso_rd_side #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int SPREAD = 2,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         stall_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
  input  logic [DEPTH-1:0]             vld_i,
  output logic [DEPTH-1:0]             tok_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         empty_o
);
  import meso_sync_pkg::*;

  logic [PTR_W-1:0] rp_q;
  logic [DEPTH-1:0] tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rp_q <= PTR_W'(SPREAD);
    else         rp_q <= PTR_W'(ring_next(int'(rp_q), DEPTH));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tok
    logic t_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    t_q <= 1'b1;
      else if (rp_q == PTR_W'(i))     t_q <= ~stall_i;
    end
    assign tok_q[i] = t_q;
  end

  assign tok_o   = tok_q;
  assign rdata_o = data_i[rp_q];
  assign empty_o = ~vld_i[rp_q];

  assert_rp_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> rp_q == PTR_W'(SPREAD));

  assert_rp_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rp_q == PTR_W'(ring_next(int'($past(rp_q)), DEPTH)));

  assert_tok_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !tok_q[$past(rp_q)]);

  assert_tok_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> tok_q[$past(rp_q)]);
endmodule

// File: rtl/meso_sync.sv
module meso_sync #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int SPREAD = DEPTH / 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              stall_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic                         wrst_n;
  logic                         rrst_n;
  logic [DEPTH-1:0][DATA_W-1:0] ring_data;
  logic [DEPTH-1:0]             ring_vld;
  logic [DEPTH-1:0]             ring_tok;

  meso_rst_sync u_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n));
  meso_rst_sync u_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n));

  meso_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr (
    .clk_i  (wclk_i),
    .rst_ni (wrst_n),
    .push_i (push_i),
    .wdata_i(wdata_i),
    .tok_i  (ring_tok),
    .data_o (ring_data),
    .vld_o  (ring_vld),
    .full_o (full_o)
  );

  meso_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SPREAD(SPREAD), .PTR_W(PTR_W)) u_rd (
    .clk_i  (rclk_i),
    .rst_ni (rrst_n),
    .stall_i(stall_i),
    .data_i (ring_data),
    .vld_i  (ring_vld),
    .tok_o  (ring_tok),
    .rdata_o(rdata_o),
    .empty_o(empty_o)
  );
endmodule

// File: tb/meso_sync_bench.sv
`timescale 1ns/1ps
module meso_sync_bench;
  localparam int W    = 16;
  localparam int D    = 4;
  localparam int MAXW = 2048;
  localparam logic [W-1:0] MARK = 16'hDEAD;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic push = 1'b0, stall = 1'b0;
  logic [W-1:0] wdata = '0;
  logic full, empty;
  logic [W-1:0] rdata;
  realtime phase = 1.0;

  int tests = 0, fails = 0;
  logic [W-1:0] exp_q [MAXW];
  int n_exp = 0;
  logic [W-1:0] got_q [MAXW];
  int got_cyc [MAXW];
  int n_got = 0;
  int rcyc = 0, wcyc = 0;
  logic [W-1:0] seq = 16'd1;

  meso_sync #(.DATA_W(W), .DEPTH(D)) u_meso_sync (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .push_i(push), .wdata_i(wdata), .full_o(full),
    .stall_i(stall), .rdata_o(rdata), .empty_o(empty)
  );

  always #10 wclk = ~wclk;
  always @(wclk) rclk <= #(phase) wclk;

  // receiver takes every presented word
  always @(negedge rclk) begin
    rcyc <= rcyc + 1;
    if (!empty && n_got < MAXW) begin
      got_q[n_got]   <= rdata;
      got_cyc[n_got] <= rcyc;
      n_got          <= n_got + 1;
    end
  end

  always @(posedge wclk) begin
    wcyc <= wcyc + 1;
    if (wcyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wcyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_w(int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic do_reset(realtime ph);
    @(negedge wclk);
    rst_n = 1'b0; push = 1'b0; stall = 1'b0;
    wait_w(3);
    phase = ph;
    wait_w(4);
    rst_n = 1'b1;
    wait_w(6);
  endtask

  task automatic send_words(int n, int gap);
    int k = 0;
    int c = 0;
    while (k < n) begin
      @(negedge wclk);
      if (!full && (c % gap) == 0) begin
        push = 1'b1; wdata = seq;
        exp_q[n_exp] = seq; n_exp++; seq++; k++;
      end else begin
        push = 1'b0;
      end
      c++;
    end
    @(negedge wclk);
    push = 1'b0;
  endtask

  task automatic verify(string req, int e0, int g0);
    int bad = -1;
    check((n_got - g0) == (n_exp - e0), req, "word count", n_got - g0, n_exp - e0);
    for (int i = 0; i < n_exp - e0 && i < n_got - g0; i++)
      if (bad < 0 && got_q[g0 + i] != exp_q[e0 + i]) bad = i;
    check(bad < 0, req, "order/data",
          (bad < 0) ? 0 : int'(got_q[g0 + bad]), (bad < 0) ? 0 : int'(exp_q[e0 + bad]));
  endtask

  // R1 R9: state right after each reset release
  task automatic t_reset(realtime ph);
    do_reset(ph);
    check(full == 1'b0, "R1", "full after reset", full, 0);
    check(empty == 1'b1, "R1 R7", "empty after reset", empty, 1);
  endtask

  // R2 R3 R4 R7 R9: back-to-back stream
  task automatic t_stream(int n);
    int e0 = n_exp, g0 = n_got;
    send_words(n, 1);
    wait_w(3 * D + 4);
    verify("R3 R7 R9", e0, g0);
    check((got_cyc[n_got - 1] - got_cyc[g0]) == n - 1, "R2 R4", "stream span",
          got_cyc[n_got - 1] - got_cyc[g0], n - 1);
  endtask

  // R3 R8: sparse pushes, each shown once
  task automatic t_gapped(int n, int gap);
    int e0 = n_exp, g0 = n_got;
    send_words(n, gap);
    wait_w(5 * D);
    verify("R3 R8", e0, g0);
  endtask

  // R5 R6 R10: hold, full, discarded push, release
  task automatic t_stall(int n);
    int e0 = n_exp, g0 = n_got;
    int seen_mark = 0;
    @(negedge rclk);
    stall = 1'b1;
    for (int i = 0; i < 3 * D; i++) begin
      @(negedge wclk);
      if (!full) begin
        push = 1'b1; wdata = seq;
        exp_q[n_exp] = seq; n_exp++; seq++;
      end else push = 1'b0;
    end
    @(negedge wclk);
    push = 1'b0;
    wait_w(2 * D);
    check(full == 1'b1, "R6 R10", "full while stalled", full, 1);
    check(empty == 1'b1, "R10", "empty while stalled", empty, 1);
    @(negedge wclk);
    push = 1'b1; wdata = MARK;
    @(negedge wclk);
    push = 1'b0;
    check(full == 1'b1, "R5", "full after discarded push", full, 1);
    @(negedge rclk);
    stall = 1'b0;
    wait_w(2 * D + 2);
    check(full == 1'b0, "R10", "full after release", full, 0);
    send_words(n, 1);
    wait_w(3 * D + 4);
    for (int i = g0; i < n_got; i++) if (got_q[i] == MARK) seen_mark++;
    check(seen_mark == 0, "R5", "discarded word delivered", seen_mark, 0);
    verify("R3 R10", e0, g0);
  endtask

  // R8: one word, many laps, shown once
  task automatic t_lone();
    int e0 = n_exp, g0 = n_got;
    send_words(1, 1);
    wait_w(6 * D);
    check((n_got - g0) == 1, "R8", "lone word count", n_got - g0, 1);
    verify("R8", e0, g0);
  endtask

  initial begin
    realtime ph_list [5] = '{0.5, 5.0, 10.0, 14.5, 19.5};
    for (int p = 0; p < 5; p++) begin
      t_reset(ph_list[p]);
      t_stream(40);
      t_gapped(12, 3);
      t_lone();
      t_stall(10);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule